// File: doc/BRIEF.md
# PN Code Generator Host Register Block

This block is the host-facing control surface of a memory-based pseudo-noise code generator. A host addresses one of a small set of word registers with a 6-bit index and separate write and read strobes. Through them it programs the shift-enable length, the code length and the code start address. It also fills and inspects a 4-bit-wide code RAM through an auto-advancing pointer, and it controls the shift-enable state with a 2-bit command. The sequencer that walks the code is a separate block. It sees the programmed values on dedicated outputs and reads the RAM through its own combinational port.

Shift enable can be started at once or armed so that it starts on the next rising edge of an external trigger. A status read shows whether shift enable is active. The RAM pointer is loaded from the start address only on a cycle marked by the code-clock strobe `code_tick`. Software is expected to read the pointer back before it moves RAM data. RAM data access and start-address writes take effect only while shift enable is off.

Top module: `pn_host_regs`

## Requirements
- R1: After synchronous reset, all programmed registers, the RAM pointer, the armed state and `shift_en` are zero. Code RAM contents are not reset.
- R2: A write to index 0 stores `host_wdata[11:0]` as the shift-enable length. A write to index 1 stores all 16 bits as the code length. Reads of indices 0 and 1 return the stored value, zero-extended. Index 2 behaves the same way for the start address, subject to R8.
- R3: An accepted write to index 2 makes a pointer load pending. The pointer takes the written value at the first clock edge whose cycle has `code_tick` high and the load pending. In any other cycle the pending load stays pending. A read of index 5 returns the 16-bit pointer.
- R4: While shift enable is off, a write to index 3 stores `host_wdata[3:0]` at the RAM entry addressed by the low pointer bits. A read of index 3 returns that entry in bits 3:0. Either access advances the pointer by one, modulo 2^16. A pointer load applied in the same cycle overrides the advance.
- R5: A write to index 4 takes a command from `host_wdata[1:0]`. 0 changes nothing. 1 clears shift enable and the armed state. 2 clears shift enable and arms. 3 sets shift enable and disarms. The change is visible the cycle after the write.
- R6: While armed, a cycle with `trig` high that follows a cycle with `trig` low sets shift enable and disarms. A non-NOP command written in that same cycle takes priority.
- R7: A read of index 4 returns shift enable in bit 0 and zeros in bits 15:1.
- R8: While shift enable is on, index 3 writes leave the RAM and the pointer unchanged. Index 3 reads return zero and do not advance the pointer. Index 2 writes change neither the start address nor the pointer.
- R9: Writes to indices 6 to 63 change nothing. `host_rdata` is zero when `host_rd` is low, when `host_wr` is high, or when the index is 6 to 63.
- R10: `seq_data` always shows the RAM entry at the low bits of `seq_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_idx | input | 6 | Register index |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, combinational |
| trig | input | 1 | External start trigger |
| code_tick | input | 1 | Code-clock strobe that applies a pending pointer load |
| shift_en | output | 1 | Shift enable to the sequencer |
| shift_len | output | SLEN_W | Shift-enable length minus one |
| code_len | output | 16 | Code length minus one |
| start_addr | output | 16 | Code start address |
| seq_addr | input | 16 | Sequencer RAM read address |
| seq_data | output | DATA_W | Sequencer RAM read data |

## Verification
The bench aims at the window between a start-address write and the next `code_tick`. A design that loaded the pointer at once, or dropped a load when a new write arrived on a tick, would return the wrong pointer or put RAM data at the wrong entry. It also raises `trig` while arming and holds it high, to show that only a fresh rising edge fires. A level-sensitive trigger would start shifting early. Writes and reads of RAM data while running are mixed in at random. A design without gating would corrupt entries, or advance the pointer, that later reads check.

// File: rtl/pn_host_pkg.sv
package pn_host_pkg;

    localparam int WORD_W = 16;
    localparam int IDX_W  = 6;

    localparam logic [IDX_W-1:0] REG_SLEN  = 6'd0;
    localparam logic [IDX_W-1:0] REG_CLEN  = 6'd1;
    localparam logic [IDX_W-1:0] REG_START = 6'd2;
    localparam logic [IDX_W-1:0] REG_RAM   = 6'd3;
    localparam logic [IDX_W-1:0] REG_CTRL  = 6'd4;
    localparam logic [IDX_W-1:0] REG_PTR   = 6'd5;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_HALT = 2'd1,
        CMD_ARM  = 2'd2,
        CMD_GO   = 2'd3
    } pn_cmd_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } host_req_t;

    typedef struct packed {
        logic slen_we;
        logic clen_we;
        logic start_we;
        logic ram_we;
        logic ram_re;
        logic cmd_we;
        logic rd_en;
    } host_stb_t;

    function automatic pn_cmd_e to_cmd(input logic [WORD_W-1:0] d);
        return pn_cmd_e'(d[1:0]);
    endfunction

endpackage

// File: rtl/pn_req_decode.sv
module pn_req_decode
    import pn_host_pkg::*;
(
    input  host_req_t req,
    input  logic      stopped,
    output host_stb_t stb
);
    always_comb begin
        stb = '0;
        if (req.wr) begin
            case (req.idx)
                REG_SLEN:  stb.slen_we  = 1'b1;
                REG_CLEN:  stb.clen_we  = 1'b1;
                REG_START: stb.start_we = stopped;
                REG_RAM:   stb.ram_we   = stopped;
                REG_CTRL:  stb.cmd_we   = 1'b1;
                default:   ;
            endcase
        end else if (req.rd) begin
            stb.rd_en  = 1'b1;
            stb.ram_re = (req.idx == REG_RAM) && stopped;
        end
    end
endmodule

// File: rtl/pn_shift_ctl.sv
module pn_shift_ctl
    import pn_host_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_we,
    input  pn_cmd_e cmd,
    input  logic    trig,
    output logic    shift_en,
    output logic    armed,
    output logic    trig_q
);
    logic trig_rise;
    assign trig_rise = trig && !trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_en <= 1'b0;
            armed    <= 1'b0;
            trig_q   <= 1'b0;
        end else begin
            trig_q <= trig;
            if (cmd_we && cmd != CMD_NOP) begin
                case (cmd)
                    CMD_HALT: begin shift_en <= 1'b0; armed <= 1'b0; end
                    CMD_ARM:  begin shift_en <= 1'b0; armed <= 1'b1; end
                    CMD_GO:   begin shift_en <= 1'b1; armed <= 1'b0; end
                    default:  ;
                endcase
            end else if (armed && trig_rise) begin
                shift_en <= 1'b1;
                armed    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pn_code_ram.sv
module pn_code_ram
    import pn_host_pkg::*;
#(
    parameter int RAM_AW = 10,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              code_tick,
    input  logic              ld_req,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              ram_we,
    input  logic              ram_re,
    input  logic [DATA_W-1:0] wdata,
    input  logic [WORD_W-1:0] seq_addr,
    output logic [WORD_W-1:0] ptr,
    output logic              ld_pend,
    output logic [WORD_W-1:0] ld_val,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] seq_data
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [RAM_AW-1:0] host_loc;

    assign host_loc = ptr[RAM_AW-1:0];

    always_ff @(posedge clk) begin
        if (ram_we) mem[host_loc] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            ld_pend <= 1'b0;
            ld_val  <= '0;
        end else begin
            if (ld_pend && code_tick)
                ptr <= ld_val;
            else if (ram_we || ram_re)
                ptr <= ptr + 1'b1;

            if (ld_req) begin
                ld_pend <= 1'b1;
                ld_val  <= ld_data;
            end else if (code_tick) begin
                ld_pend <= 1'b0;
            end
        end
    end

    assign rd_data  = mem[host_loc];
    assign seq_data = mem[seq_addr[RAM_AW-1:0]];
endmodule

// File: rtl/pn_host_regs.sv
module pn_host_regs
    import pn_host_pkg::*;
#(
    parameter int SLEN_W = 12,
    parameter int RAM_AW = 10,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              trig,
    input  logic              code_tick,
    output logic              shift_en,
    output logic [SLEN_W-1:0] shift_len,
    output logic [WORD_W-1:0] code_len,
    output logic [WORD_W-1:0] start_addr,
    input  logic [WORD_W-1:0] seq_addr,
    output logic [DATA_W-1:0] seq_data
);
    host_req_t         req;
    host_stb_t         stb;
    logic              armed;
    logic              trig_q;
    logic [WORD_W-1:0] ram_ptr;
    logic              ld_pend;
    logic [WORD_W-1:0] ld_val;
    logic [DATA_W-1:0] ram_rd;

    assign req = '{wr: host_wr, rd: host_rd, idx: host_idx, data: host_wdata};

    pn_req_decode i_dec (
        .req     (req),
        .stopped (!shift_en),
        .stb     (stb)
    );

    pn_shift_ctl i_ctl (
        .clk      (clk),
        .rst      (rst),
        .cmd_we   (stb.cmd_we),
        .cmd      (to_cmd(host_wdata)),
        .trig     (trig),
        .shift_en (shift_en),
        .armed    (armed),
        .trig_q   (trig_q)
    );

    pn_code_ram #(.RAM_AW(RAM_AW), .DATA_W(DATA_W)) i_ram (
        .clk       (clk),
        .rst       (rst),
        .code_tick (code_tick),
        .ld_req    (stb.start_we),
        .ld_data   (host_wdata),
        .ram_we    (stb.ram_we),
        .ram_re    (stb.ram_re),
        .wdata     (host_wdata[DATA_W-1:0]),
        .seq_addr  (seq_addr),
        .ptr       (ram_ptr),
        .ld_pend   (ld_pend),
        .ld_val    (ld_val),
        .rd_data   (ram_rd),
        .seq_data  (seq_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_len  <= '0;
            code_len   <= '0;
            start_addr <= '0;
        end else begin
            if (stb.slen_we)  shift_len  <= host_wdata[SLEN_W-1:0];
            if (stb.clen_we)  code_len   <= host_wdata;
            if (stb.start_we) start_addr <= host_wdata;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (stb.rd_en) begin
            case (host_idx)
                REG_SLEN:  host_rdata = WORD_W'(shift_len);
                REG_CLEN:  host_rdata = code_len;
                REG_START: host_rdata = start_addr;
                REG_RAM:   if (!shift_en) host_rdata = WORD_W'(ram_rd);
                REG_CTRL:  host_rdata = WORD_W'(shift_en);
                REG_PTR:   host_rdata = ram_ptr;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/pn_host_regs_chk.sv
module pn_host_regs_chk
    import pn_host_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [IDX_W-1:0]  host_idx,
    input logic              host_wr,
    input logic              host_rd,
    input logic [WORD_W-1:0] host_wdata,
    input logic [WORD_W-1:0] host_rdata,
    input logic              trig,
    input logic              trig_q,
    input logic              code_tick,
    input logic              shift_en,
    input logic              armed,
    input logic [WORD_W-1:0] ram_ptr,
    input logic              ld_pend,
    input logic [WORD_W-1:0] ld_val
);
    logic cmd_wr;
    assign cmd_wr = host_wr && host_idx == REG_CTRL;

    a_r5_halt_clears: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && host_wdata[1:0] == 2'd1 |=> !shift_en && !armed);

    a_r5_go_sets: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && host_wdata[1:0] == 2'd3 |=> shift_en && !armed);

    a_r6_trigger_fires: assert property (@(posedge clk) disable iff (rst)
        armed && trig && !trig_q && !(cmd_wr && host_wdata[1:0] != 2'd0) |=> shift_en && !armed);

    a_r3_load_on_tick: assert property (@(posedge clk) disable iff (rst)
        ld_pend && code_tick |=> ram_ptr == $past(ld_val));

    a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
        shift_en && (host_wr || host_rd) && host_idx == REG_RAM && !(ld_pend && code_tick)
        |=> $stable(ram_ptr));

    a_r9_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !host_rd || host_wr |-> host_rdata == '0);
endmodule

bind pn_host_regs pn_host_regs_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .host_idx   (host_idx),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .trig       (trig),
    .trig_q     (trig_q),
    .code_tick  (code_tick),
    .shift_en   (shift_en),
    .armed      (armed),
    .ram_ptr    (ram_ptr),
    .ld_pend    (ld_pend),
    .ld_val     (ld_val)
);

// File: tb/test_pn_host_regs.sv
module test_pn_host_regs;
    localparam int SLEN_W = 12;
    localparam int RAM_AW = 10;
    localparam int DATA_W = 4;
    localparam int DEPTH  = 1 << RAM_AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  host_idx = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        trig = 1'b0;
    logic        code_tick = 1'b0;
    logic        shift_en;
    logic [SLEN_W-1:0] shift_len;
    logic [15:0] code_len;
    logic [15:0] start_addr;
    logic [15:0] seq_addr = '0;
    logic [DATA_W-1:0] seq_data;

    int checks = 0;
    int failures = 0;

    // reference model state
    logic [SLEN_W-1:0] m_slen;
    logic [15:0] m_clen, m_start, m_ptr, m_ldv;
    logic        m_pend, m_se, m_arm, m_tq;
    logic [DATA_W-1:0] m_ram [DEPTH];
    bit          m_ok [DEPTH];

    pn_host_regs #(.SLEN_W(SLEN_W), .RAM_AW(RAM_AW), .DATA_W(DATA_W)) i_pn_host_regs (
        .clk(clk), .rst(rst), .host_idx(host_idx), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .trig(trig), .code_tick(code_tick),
        .shift_en(shift_en), .shift_len(shift_len), .code_len(code_len),
        .start_addr(start_addr), .seq_addr(seq_addr), .seq_data(seq_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_for(input logic [5:0] a);
        case (a)
            6'd0, 6'd1, 6'd2: return "R2";
            6'd3: return m_se ? "R8" : "R4";
            6'd4: return "R7";
            6'd5: return "R3";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [15:0] exp_read(input logic [5:0] a);
        case (a)
            6'd0: return 16'(m_slen);
            6'd1: return m_clen;
            6'd2: return m_start;
            6'd3: return m_se ? 16'h0 : 16'(m_ram[m_ptr[RAM_AW-1:0]]);
            6'd4: return {15'h0, m_se};
            6'd5: return m_ptr;
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_slen = '0; m_clen = '0; m_start = '0; m_ptr = '0; m_ldv = '0;
        m_pend = 0; m_se = 0; m_arm = 0; m_tq = 0;
        for (int i = 0; i < DEPTH; i++) m_ok[i] = 0;
    endtask

    task automatic model_step(input logic [5:0] a, input logic w, r,
                              input logic [15:0] d, input logic tg, tk);
        logic stopped, adv, ld_new, rise;
        logic [15:0] n_ptr;
        stopped = !m_se; adv = 0; ld_new = 0;
        rise = tg && !m_tq;
        n_ptr = m_ptr;
        if (w) begin
            case (a)
                6'd0: m_slen = d[SLEN_W-1:0];
                6'd1: m_clen = d;
                6'd2: if (stopped) begin m_start = d; ld_new = 1; end
                6'd3: if (stopped) begin
                    m_ram[m_ptr[RAM_AW-1:0]] = d[DATA_W-1:0];
                    m_ok[m_ptr[RAM_AW-1:0]] = 1; adv = 1;
                end
                default: ;
            endcase
        end else if (r && a == 6'd3 && stopped) adv = 1;
        if (m_pend && tk) n_ptr = m_ldv;
        else if (adv) n_ptr = m_ptr + 16'd1;
        m_ptr = n_ptr;
        if (ld_new) begin m_pend = 1; m_ldv = d; end
        else if (tk) m_pend = 0;
        if (w && a == 6'd4 && d[1:0] != 2'd0) begin
            case (d[1:0])
                2'd1: begin m_se = 0; m_arm = 0; end
                2'd2: begin m_se = 0; m_arm = 1; end
                default: begin m_se = 1; m_arm = 0; end
            endcase
        end else if (m_arm && rise) begin m_se = 1; m_arm = 0; end
        m_tq = tg;
    endtask

    task automatic step(input logic [5:0] a, input logic w, r,
                        input logic [15:0] d, input logic tg, tk);
        @(negedge clk);
        host_idx = a; host_wr = w; host_rd = r; host_wdata = d;
        trig = tg; code_tick = tk; seq_addr = 16'($urandom);
        #1;
        if (r && !w) begin
            if (!(a == 6'd3 && !m_se && !m_ok[m_ptr[RAM_AW-1:0]]))
                check(tag_for(a), 32'(host_rdata), 32'(exp_read(a)));
        end else begin
            check("R9", 32'(host_rdata), 32'h0);
        end
        if (m_ok[seq_addr[RAM_AW-1:0]])
            check("R10", 32'(seq_data), 32'(m_ram[seq_addr[RAM_AW-1:0]]));
        check("R6", 32'(shift_en), 32'(m_se));
        @(posedge clk);
        model_step(a, w, r, d, tg, tk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic tk = 0);
        step(a, 1, 0, d, trig, tk);
    endtask
    task automatic rd(input logic [5:0] a, input logic tk = 0);
        step(a, 0, 1, 16'h0, trig, tk);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4447));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset values visible at ports and through reads
        #1;
        check("R1", 32'(shift_en), 0);
        check("R1", 32'(shift_len), 0);
        check("R1", 32'(code_len), 0);
        check("R1", 32'(start_addr), 0);
        for (int i = 0; i < 6; i++) step(6'(i), 0, 1, 0, 0, 0);

        // R2: programming and read-back, upper bits of index 0 dropped
        wr(0, 16'hFABC); wr(1, 16'h1234);
        rd(0); rd(1);
        check("R2", 32'(shift_len), 32'h0ABC);
        check("R2", 32'(code_len), 32'h1234);

        // R3: pointer load waits for code_tick
        wr(2, 16'h0010); rd(5); rd(5);
        check("R3", 32'(start_addr), 32'h0010);
        rd(5, 1); rd(5);

        // R4: RAM fill with auto advance, reload, read back
        wr(3, 16'h0005); wr(3, 16'h0006); wr(3, 16'hFFF7); rd(5);
        wr(2, 16'h0010, 1); rd(5, 1); rd(5);
        rd(3); rd(3); rd(3); rd(5);
        // R3: new write on a tick cycle keeps the new load pending
        wr(2, 16'h0040); wr(2, 16'h0080, 1); rd(5); rd(5, 1); rd(5);

        // R5 and R8: running blocks RAM and start-address access
        wr(4, 16'h0003); rd(4);
        wr(3, 16'h000F); rd(3); rd(5); wr(2, 16'h0300, 1); rd(2); rd(5, 1);
        wr(4, 16'h0000); rd(4);
        wr(4, 16'h0001); rd(4);
        wr(2, 16'h0080, 1); rd(5, 1); rd(3);

        // R6: arming with trigger already high does not fire; fresh edge does
        step(4, 1, 0, 16'h0002, 1, 0);
        step(4, 0, 1, 0, 1, 0); step(4, 0, 1, 0, 1, 0);
        step(4, 0, 1, 0, 0, 0);
        step(4, 0, 1, 0, 1, 0); step(4, 0, 1, 0, 1, 0);
        // R6: halt on the trigger edge wins
        step(4, 1, 0, 16'h0002, 0, 0);
        step(4, 1, 0, 16'h0001, 1, 0);
        step(4, 0, 1, 0, 0, 0);

        // R9: undefined indices
        wr(6'd63, 16'hFFFF); wr(6'd6, 16'h1111);
        rd(6'd63); rd(6'd6); rd(6'd40);
        rd(0); rd(1); rd(2); rd(5);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] a;
            logic [15:0] d;
            int op;
            a = ($urandom % 8 == 0) ? 6'($urandom % 64) : 6'($urandom % 6);
            d = 16'($urandom);
            if (a == 6'd4) d[1:0] = ($urandom % 2 == 0) ? 2'd1 : 2'($urandom);
            op = $urandom % 3;
            step(a, op == 0, op == 1, d, ($urandom % 6) == 0, ($urandom % 3) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule